// File: doc/BRIEF.md
# CRC-Gated Fast-Path Convolutional Decoder

This block receives a frame one bit at a time. The frame holds rate 1/2, constraint length 3 convolutionally coded bits, followed by a 32-bit CRC that the transmitter computed over those coded bits. While the bits arrive, the block stores the coded bits and checks the CRC. The trailing 32 bits are held back in a sliding window until the frame ends, so the block does not need to know the frame length in advance.

When the CRC matches, the block decodes the stored symbols with a precomputed table. The table maps the encoder state and a received symbol to a decoded bit and a next state, so no trellis search takes place. If the CRC fails, or if any symbol has no entry in the table, the block sends the stored symbols in order to an external Viterbi decoder over a request port. It then forwards that decoder's response as its own output. A path flag goes with each decoded bit: 0 means the table path was used and 1 means the external decoder was used. A last marker tags the final decoded bit of each frame.

Top module: `crc_gated_decoder`

## Requirements
- R1: The CRC is CRC-32 with polynomial 0x04C11DB7, processed reflected (LSB-first form 0xEDB88320), with initial value 0xFFFFFFFF and final XOR 0xFFFFFFFF. It is computed over every frame bit except the last 32. Those last 32 bits carry the expected CRC, with bit 0 sent first. The frame passes when the two values are equal.
- R2: Coded bits arrive as symbols of two bits. The first bit is the output of generator G1 (default 111) and the second is the output of G2 (default 101). A transfer happens on a cycle with in_valid and in_ready both high. in_last marks the final CRC bit.
- R3: When the frame passes and every symbol has a table entry, the block emits one decoded bit per symbol, in message order, with out_path = 0. The walk starts from state 0, and no request is issued to the external decoder.
- R4: The encoder state is {u[t-1], u[t-2]}. For a given state, the input u produces the symbol {u^s1^s0, u^s0} under the default generators, and the next state is {u, s1}. A table entry is valid only if the received symbol equals one of the two symbols that are possible from that state.
- R5: When the CRC fails, the stored symbols go out in order on vit_req_sym, with the first coded bit as bit 1. vit_req_last is set on the final symbol. Each request holds its symbol and last marker stable until vit_req_ready is high.
- R6: If a frame passes the CRC but contains a symbol with no valid table entry, the block takes the fallback path of R5.
- R7: On the fallback path, each vit_rsp_valid beat is forwarded to the output one cycle later. The forwarded beat carries the same bit and last marker, with out_path = 1.
- R8: out_last is high on the final decoded bit of a frame only. out_path is valid with every out_valid beat and stays the same for the whole frame.
- R9: A frame may hold up to 64 symbols. in_ready goes low in the cycle after the last frame bit is accepted. It returns high only after the final decoded bit has been emitted.
- R10: After reset, in_ready is 1, and out_valid and vit_req_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input bit valid |
| in_bit | input | 1 | Serial frame bit |
| in_last | input | 1 | Marks the final CRC bit of a frame |
| in_ready | output | 1 | Block can accept a frame bit |
| out_valid | output | 1 | Decoded bit valid |
| out_bit | output | 1 | Decoded message bit |
| out_last | output | 1 | Final decoded bit of the frame |
| out_path | output | 1 | 0 = table path, 1 = external decoder path |
| vit_req_valid | output | 1 | Symbol request to external decoder valid |
| vit_req_sym | output | 2 | Symbol, first coded bit in bit 1 |
| vit_req_last | output | 1 | Final symbol of the frame |
| vit_req_ready | input | 1 | External decoder accepts the symbol |
| vit_rsp_valid | input | 1 | External decoder output bit valid |
| vit_rsp_bit | input | 1 | External decoder output bit |
| vit_rsp_last | input | 1 | Final bit of the external decoder output |

## Verification
The assertions rely on a few properties of the input. Frames are taken to hold an even number of coded bits, at least one symbol and no more than 64 symbols, ahead of the 32 CRC bits. The external decoder is taken to respond only after it has accepted the final request symbol, and to finish its response with exactly one last marker. The bench encodes its messages with a model of the encoder, so the coded length is always twice the message length. It starts its response model only after it has seen the request carrying the last marker. It also toggles vit_req_ready, which exercises the rule that a request must hold until it is accepted.

// File: rtl/cgd_pkg.sv
package cgd_pkg;
  localparam int STW = 2;

  typedef enum logic [2:0] {
    ST_RECV, ST_SCAN, ST_EMIT, ST_VREQ, ST_VRSP
  } ctl_state_e;

  typedef struct packed {
    logic           ok;
    logic           dbit;
    logic [STW-1:0] nxt;
  } lut_entry_t;

  function automatic logic [1:0] enc_sym(input logic [2:0] g1, input logic [2:0] g2,
                                         input logic u, input logic [STW-1:0] s);
    logic [2:0] taps;
    taps = {u, s};
    return {^(g1 & taps), ^(g2 & taps)};
  endfunction

  function automatic lut_entry_t lut_calc(input logic [2:0] g1, input logic [2:0] g2,
                                          input logic [STW-1:0] s, input logic [1:0] sym);
    lut_entry_t e;
    if (enc_sym(g1, g2, 1'b0, s) == sym) begin
      e = '{ok: 1'b1, dbit: 1'b0, nxt: {1'b0, s[1]}};
    end else if (enc_sym(g1, g2, 1'b1, s) == sym) begin
      e = '{ok: 1'b1, dbit: 1'b1, nxt: {1'b1, s[1]}};
    end else begin
      e = '{ok: 1'b0, dbit: 1'b0, nxt: '0};
    end
    return e;
  endfunction
endpackage

// File: rtl/crc_gate.sv
module crc_gate #(
  parameter int          CRC_W    = 32,
  parameter logic [31:0] POLY_REV = 32'hEDB88320
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_en,
  input  logic bit_in,
  output logic pop_en,
  output logic pop_bit,
  output logic crc_ok
);
  localparam int FW = $clog2(CRC_W + 1);

  logic [CRC_W-1:0] win_q, win_d, crc_q, crc_d;
  logic [FW-1:0]    fill_q, fill_d;
  logic             full;

  assign full    = (fill_q == FW'(CRC_W));
  assign pop_en  = bit_en && full;
  assign pop_bit = win_q[0];
  assign crc_ok  = full && (win_q == ~crc_q);

  always_comb begin
    win_d  = win_q;
    fill_d = fill_q;
    crc_d  = crc_q;
    if (clr) begin
      win_d  = '0;
      fill_d = '0;
      crc_d  = '1;
    end else if (bit_en) begin
      win_d = {bit_in, win_q[CRC_W-1:1]};
      if (!full) fill_d = fill_q + FW'(1);
      if (pop_en) begin
        crc_d = (crc_q >> 1) ^ ((crc_q[0] ^ pop_bit) ? POLY_REV[CRC_W-1:0] : '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
      crc_q  <= '1;
    end else begin
      win_q  <= win_d;
      fill_q <= fill_d;
      crc_q  <= crc_d;
    end
  end

  // R1: the checker fill never exceeds the CRC width
  p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FW'(CRC_W));
endmodule

// File: rtl/sym_buffer.sv
module sym_buffer #(
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         wr_en,
  input  logic                         wr_bit,
  input  logic [$clog2(DEPTH)-1:0]     rd_idx,
  output logic [1:0]                   rd_sym,
  output logic [$clog2(DEPTH+1)-1:0]   nsym
);
  localparam int NB  = 2 * DEPTH;
  localparam int IW  = $clog2(NB + 1);
  localparam int RIW = $clog2(DEPTH);

  logic [NB-1:0] mem;
  logic [IW-1:0] wptr_q, wptr_d;
  logic [RIW:0]  base;

  assign base   = {rd_idx, 1'b0};
  assign rd_sym = {mem[base], mem[base + (RIW+1)'(1)]};
  assign nsym   = wptr_q[IW-1:1];

  always_comb begin
    wptr_d = wptr_q;
    if (clr)        wptr_d = '0;
    else if (wr_en) wptr_d = wptr_q + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wptr_q <= '0;
    else        wptr_q <= wptr_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr) mem[wptr_q[IW-2:0]] <= wr_bit;
  end

  // R9: at most DEPTH symbols are stored per frame
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |-> (wptr_q < IW'(NB)));
endmodule

// File: rtl/fast_lut.sv
module fast_lut
  import cgd_pkg::*;
#(
  parameter logic [2:0] G1 = 3'b111,
  parameter logic [2:0] G2 = 3'b101
) (
  input  logic [STW-1:0] state,
  input  logic [1:0]     sym,
  output lut_entry_t     entry
);
  localparam int NE = 1 << (STW + 2);

  lut_entry_t tbl [NE];

  for (genvar i = 0; i < NE; i++) begin : g_ent
    localparam logic [STW+1:0] IDX = (STW+2)'(i);
    assign tbl[i] = lut_calc(G1, G2, IDX[STW+1:2], IDX[1:0]);
  end

  assign entry = tbl[{state, sym}];
endmodule

// File: rtl/crc_gated_decoder.sv
module crc_gated_decoder
  import cgd_pkg::*;
#(
  parameter int         DEPTH = 64,
  parameter logic [2:0] G1    = 3'b111,
  parameter logic [2:0] G2    = 3'b101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_bit,
  input  logic       in_last,
  output logic       in_ready,
  output logic       out_valid,
  output logic       out_bit,
  output logic       out_last,
  output logic       out_path,
  output logic       vit_req_valid,
  output logic [1:0] vit_req_sym,
  output logic       vit_req_last,
  input  logic       vit_req_ready,
  input  logic       vit_rsp_valid,
  input  logic       vit_rsp_bit,
  input  logic       vit_rsp_last
);
  localparam int RIW = $clog2(DEPTH);
  localparam int NSW = $clog2(DEPTH + 1);

  ctl_state_e     st_q, st_d;
  logic [RIW-1:0] idx_q, idx_d;
  logic [STW-1:0] ds_q, ds_d;
  logic           ov_q, ob_q, ol_q, op_q;
  logic           ov_d, ob_d, ol_d, op_d;
  logic           acc, clr, pop_en, pop_bit, crc_ok, last_sym;
  logic [1:0]     rd_sym;
  logic [NSW-1:0] nsym;
  lut_entry_t     entry;

  assign acc = in_valid && in_ready;

  crc_gate u_crc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_en(acc), .bit_in(in_bit),
    .pop_en(pop_en), .pop_bit(pop_bit), .crc_ok(crc_ok)
  );

  sym_buffer #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(pop_en), .wr_bit(pop_bit),
    .rd_idx(idx_q), .rd_sym(rd_sym), .nsym(nsym)
  );

  fast_lut #(.G1(G1), .G2(G2)) u_lut (
    .state(ds_q), .sym(rd_sym), .entry(entry)
  );

  assign last_sym      = (({1'b0, idx_q} + NSW'(1)) == nsym);
  assign in_ready      = (st_q == ST_RECV);
  assign vit_req_valid = (st_q == ST_VREQ);
  assign vit_req_sym   = rd_sym;
  assign vit_req_last  = (st_q == ST_VREQ) && last_sym;
  assign out_valid     = ov_q;
  assign out_bit       = ob_q;
  assign out_last      = ol_q;
  assign out_path      = op_q;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    ds_d  = ds_q;
    clr   = 1'b0;
    ov_d  = 1'b0;
    ob_d  = ob_q;
    ol_d  = 1'b0;
    op_d  = op_q;
    unique case (st_q)
      ST_RECV: begin
        if (acc && in_last) begin
          st_d  = ST_SCAN;
          idx_d = '0;
          ds_d  = '0;
        end
      end
      ST_SCAN: begin
        if (!crc_ok || !entry.ok) begin
          st_d  = ST_VREQ;
          idx_d = '0;
        end else if (last_sym) begin
          st_d  = ST_EMIT;
          idx_d = '0;
          ds_d  = '0;
        end else begin
          idx_d = idx_q + RIW'(1);
          ds_d  = entry.nxt;
        end
      end
      ST_EMIT: begin
        ov_d  = 1'b1;
        ob_d  = entry.dbit;
        ol_d  = last_sym;
        op_d  = 1'b0;
        idx_d = idx_q + RIW'(1);
        ds_d  = entry.nxt;
        if (last_sym) begin
          st_d = ST_RECV;
          clr  = 1'b1;
        end
      end
      ST_VREQ: begin
        if (vit_req_ready) begin
          if (last_sym) st_d = ST_VRSP;
          else          idx_d = idx_q + RIW'(1);
        end
      end
      ST_VRSP: begin
        if (vit_rsp_valid) begin
          ov_d = 1'b1;
          ob_d = vit_rsp_bit;
          ol_d = vit_rsp_last;
          op_d = 1'b1;
          if (vit_rsp_last) begin
            st_d = ST_RECV;
            clr  = 1'b1;
          end
        end
      end
      default: st_d = ST_RECV;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RECV;
      idx_q <= '0;
      ds_q  <= '0;
      ov_q  <= 1'b0;
      ob_q  <= 1'b0;
      ol_q  <= 1'b0;
      op_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      ds_q  <= ds_d;
      ov_q  <= ov_d;
      ob_q  <= ob_d;
      ol_q  <= ol_d;
      op_q  <= op_d;
    end
  end

  // R9: input closes right after the frame's last bit
  p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_last) |=> !in_ready);

  // R5: an unaccepted request keeps its contents
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vit_req_valid && !vit_req_ready) |=>
      (vit_req_valid && $stable(vit_req_sym) && $stable(vit_req_last)));

  // R6: the table path only emits from valid table entries
  p_emit_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EMIT) |-> entry.ok);

  // R8: path flag constant across consecutive beats
  p_path_const_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> (out_path == $past(out_path)));

  // R8: last marker only on a valid beat
  p_last_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R3: no external request while the table path emits
  p_fast_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_path) |-> !vit_req_valid);
endmodule

// File: tb/tb_crc_gated_decoder.sv
module tb_crc_gated_decoder;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_bit, in_last, in_ready;
  logic out_valid, out_bit, out_last, out_path;
  logic vit_req_valid, vit_req_last, vit_req_ready;
  logic [1:0] vit_req_sym;
  logic vit_rsp_valid, vit_rsp_bit, vit_rsp_last;

  always #2 clk = ~clk;

  crc_gated_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit), .in_last(in_last),
    .in_ready(in_ready), .out_valid(out_valid), .out_bit(out_bit), .out_last(out_last),
    .out_path(out_path), .vit_req_valid(vit_req_valid), .vit_req_sym(vit_req_sym),
    .vit_req_last(vit_req_last), .vit_req_ready(vit_req_ready),
    .vit_rsp_valid(vit_rsp_valid), .vit_rsp_bit(vit_rsp_bit), .vit_rsp_last(vit_rsp_last)
  );

  int checks = 0;
  int errors = 0;

  logic fb  [0:199];
  int   fn;
  logic msg [0:63];
  int   mn;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // encoder with generators 111 / 101, state {u[t-1],u[t-2]}
  task automatic build_coded();
    logic s1, s0;
    s1 = 1'b0; s0 = 1'b0;
    fn = 0;
    for (int i = 0; i < mn; i++) begin
      fb[fn]   = msg[i] ^ s1 ^ s0;
      fb[fn+1] = msg[i] ^ s0;
      fn += 2;
      s0 = s1; s1 = msg[i];
    end
  endtask

  task automatic append_crc();
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < fn; i++) begin
      logic f;
      f = c[0] ^ fb[i];
      c = c >> 1;
      if (f) c = c ^ 32'hEDB88320;
    end
    c = ~c;
    for (int i = 0; i < 32; i++) fb[fn+i] = c[i];
    fn += 32;
  endtask

  task automatic run_frame(input bit exp_path, input string req);
    int nout, nreq, cyc, ridx;
    bit done, rsp_on, bad_bits, bad_last, bad_path, bad_req, bad_rlast;
    int ncoded;
    ncoded = fn - 32;
    for (int i = 0; i < fn; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_bit = fb[i]; in_last = (i == fn - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    chk(in_ready == 1'b0, {req, " R9 ready low after last"}, in_ready, 0);
    nout = 0; nreq = 0; cyc = 0; ridx = 0; done = 0; rsp_on = 0;
    bad_bits = 0; bad_last = 0; bad_path = 0; bad_req = 0; bad_rlast = 0;
    while (!done && cyc < 3000) begin
      if (vit_req_valid && vit_req_ready) begin
        if (nreq < ncoded / 2) begin
          if (vit_req_sym != {fb[2*nreq], fb[2*nreq+1]}) bad_req = 1;
        end
        if (vit_req_last != (nreq == ncoded / 2 - 1)) bad_rlast = 1;
        if (vit_req_last) rsp_on = 1;
        nreq++;
      end
      if (out_valid) begin
        if (nout < mn && out_bit != msg[nout]) bad_bits = 1;
        if (out_last != (nout == mn - 1)) bad_last = 1;
        if (out_path != exp_path) bad_path = 1;
        if (out_last) done = 1;
        nout++;
      end
      vit_req_ready = (cyc % 3 != 1);
      vit_rsp_valid = 1'b0; vit_rsp_last = 1'b0;
      if (rsp_on && ridx < mn && (cyc % 2 == 0)) begin
        vit_rsp_valid = 1'b1;
        vit_rsp_bit   = msg[ridx];
        vit_rsp_last  = (ridx == mn - 1);
        ridx++;
      end
      cyc++;
      if (!done) @(negedge clk);
    end
    vit_rsp_valid = 1'b0; vit_rsp_last = 1'b0;
    chk(nout == mn, {req, " R3 R7 decoded bit count"}, nout, mn);
    chk(!bad_bits, {req, " R3 R7 decoded bits in order"}, bad_bits, 0);
    chk(!bad_last, {req, " R8 last marker on final bit"}, bad_last, 0);
    chk(!bad_path, {req, " R8 path flag"}, bad_path, exp_path);
    if (exp_path) begin
      chk(nreq == ncoded / 2, {req, " R5 request count"}, nreq, ncoded / 2);
      chk(!bad_req, {req, " R5 request symbols"}, bad_req, 0);
      chk(!bad_rlast, {req, " R5 request last"}, bad_rlast, 0);
    end else begin
      chk(nreq == 0, {req, " R3 no external request"}, nreq, 0);
    end
    @(negedge clk);
    chk(in_ready == 1'b1, {req, " R9 ready back after frame"}, in_ready, 1);
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
    chk(vit_req_valid == 1'b0, "R10 vit_req_valid after reset", vit_req_valid, 0);
  endtask

  task automatic t_clean_short();
    mn = 4; msg[0] = 1; msg[1] = 1; msg[2] = 1; msg[3] = 0;
    build_coded(); append_crc();
    run_frame(1'b0, "R1 R3 R4 clean 1110");
  endtask

  task automatic t_clean_max();
    mn = 64;
    for (int i = 0; i < 64; i++) msg[i] = ((i * 7 + i / 5) % 3) == 0;
    build_coded(); append_crc();
    run_frame(1'b0, "R3 R9 clean 64 symbols");
  endtask

  task automatic t_clean_one();
    mn = 1; msg[0] = 1;
    build_coded(); append_crc();
    run_frame(1'b0, "R2 R3 single symbol");
  endtask

  task automatic t_coded_error();
    mn = 10;
    for (int i = 0; i < 10; i++) msg[i] = (i % 3) != 1;
    build_coded(); append_crc();
    fb[5] = ~fb[5];
    run_frame(1'b1, "R1 R5 R7 coded bit error");
  endtask

  task automatic t_crc_error();
    mn = 6;
    msg[0] = 1; msg[1] = 0; msg[2] = 0; msg[3] = 1; msg[4] = 1; msg[5] = 0;
    build_coded(); append_crc();
    fb[fn - 1] = ~fb[fn - 1];
    run_frame(1'b1, "R1 R5 CRC bit error");
  endtask

  task automatic t_invalid_entry();
    mn = 2; msg[0] = 1; msg[1] = 0;
    fb[0] = 0; fb[1] = 1; fb[2] = 1; fb[3] = 1; fn = 4;
    append_crc();
    run_frame(1'b1, "R4 R6 invalid symbol good CRC");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_bit = 1'b0; in_last = 1'b0;
    vit_req_ready = 1'b1; vit_rsp_valid = 1'b0; vit_rsp_bit = 1'b0; vit_rsp_last = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean_short();
    t_coded_error();
    t_clean_max();
    t_crc_error();
    t_clean_one();
    t_invalid_entry();
    t_clean_short();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule